// File: doc/BRIEF.md
# Spawn-Join Thread Dispatcher

This block runs one parallel region on a pool of thread control units (TCUs). A master unit opens a region by giving an inclusive range of virtual thread IDs, from a low bound to a high bound. Any idle TCU may then ask for work. The dispatcher hands it the next ID not yet issued. There is no fixed split of IDs between TCUs, so the load is balanced at run time by whichever unit happens to be free. A TCU that finishes its thread pulses done and can ask again at once.

When several TCUs ask in the same cycle, each one receives a distinct ID in the same cycle. The IDs come from a prefix count over the requesters, so the lower TCU index takes the lower ID. Once the range is used up, further requests get a no-more-work answer. The region closes when every ID has been issued and no TCU still holds a thread. At that point a one-cycle join pulse releases the master. A spawn that arrives while a region is open is refused with an error pulse, because regions do not nest.

Top module: `spawn_join_sched`

## Requirements
- R1: After reset all outputs are low and no region is open. A spawn presented while no region is open produces a one-cycle `spawn_ack` in the following cycle, and `region_busy` goes high in that same cycle.
- R2: A spawn presented while a region is open produces a one-cycle `spawn_err` in the following cycle. The open region's bounds and progress are left unchanged.
- R3: A request from a TCU that holds no thread is answered in exactly the next cycle with exactly one of `tcu_grant` or `tcu_nowork` for that TCU. A grant carries its ID on that TCU's slice of `tcu_id` (TCU i uses bits i*ID_W upward).
- R4: Requests granted in the same cycle receive distinct, consecutive IDs that rise with TCU index. TCU 0 has the highest priority.
- R5: Across a region, every ID from low to high inclusive is granted exactly once. The next free ID advances by the number of grants made in each cycle.
- R6: Once every ID of the open region has been issued, each further request gets `tcu_nowork`. When fewer IDs remain than there are requesters, the lowest-indexed requesters get the remaining IDs and the rest get `tcu_nowork`.
- R7: A request from a TCU that holds a thread draws no response of either kind. A done pulse from a TCU that holds no thread has no effect.
- R8: `join_done` pulses for one cycle in the cycle after one in which all IDs are issued and no TCU holds a thread. `region_busy` falls in that same cycle. A done pulse frees its TCU at the next clock edge.
- R9: A spawn whose high bound is below its low bound issues no IDs. Its `spawn_ack` comes one cycle after the spawn and `join_done` one cycle after that.
- R10: A request made while no region is open gets `tcu_nowork`.
- R11: A range that ends at the largest ID value (all ones) is issued in full, with no wraparound to zero, and is followed by `tcu_nowork`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spawn_valid | input | 1 | Master requests a new region this cycle |
| spawn_lo | input | ID_W | First thread ID of the region |
| spawn_hi | input | ID_W | Last thread ID of the region (inclusive) |
| spawn_ack | output | 1 | Spawn accepted (one-cycle pulse) |
| spawn_err | output | 1 | Spawn refused because a region is open (one-cycle pulse) |
| region_busy | output | 1 | A region is open |
| join_done | output | 1 | Region complete, master may resume (one-cycle pulse) |
| tcu_req | input | N_TCU | Per-TCU request for a thread ID |
| tcu_done | input | N_TCU | Per-TCU pulse: current thread has finished |
| tcu_grant | output | N_TCU | Per-TCU pulse: an ID is delivered on `tcu_id` |
| tcu_nowork | output | N_TCU | Per-TCU pulse: no ID is available |
| tcu_id | output | N_TCU*ID_W | Per-TCU granted ID, valid with `tcu_grant` |

## Verification
The bound checker watches several properties on every cycle: grant and no-work never meet on one TCU, and every response follows a request from the cycle before. IDs granted together never collide, and each grant falls inside the range captured at spawn. Ack and error are exclusive, no grant appears outside an open region, and the join pulse coincides with the fall of `region_busy`. Other behaviour spans many cycles, and only the bench scenarios can show it: that each ID is issued exactly once over a whole region, that the region closes only after the last thread returns, that busy TCUs and stray done pulses are ignored, and that empty and top-of-range regions behave correctly. The bench sweeps region sizes against contention and thread-length patterns to show these.

// File: rtl/sjs_pkg.sv
package sjs_pkg;
  // Region lifecycle of the dispatcher.
  typedef enum logic {
    RGN_IDLE = 1'b0,
    RGN_RUN  = 1'b1
  } rgn_state_e;
endpackage

// File: rtl/sjs_rst_sync.sv
// Asynchronous assertion, synchronous two-stage release.
module sjs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/sjs_rank.sv
// Prefix count over eligible requesters: each gets its rank among them.
module sjs_rank #(
  parameter int N_TCU = 8,
  parameter int RW    = 4
) (
  input  logic [N_TCU-1:0]    elig,
  output logic [N_TCU*RW-1:0] rank_flat,
  output logic [RW-1:0]       total
);
  logic [RW-1:0] pre [N_TCU+1];

  assign pre[0] = '0;

  for (genvar g = 0; g < N_TCU; g++) begin : g_pre
    assign pre[g+1]               = pre[g] + RW'(elig[g]);
    assign rank_flat[g*RW +: RW]  = pre[g];
  end

  assign total = pre[N_TCU];
endmodule

// File: rtl/sjs_issue.sv
// Decides per-TCU grant / no-work and the ID each grant carries.
module sjs_issue #(
  parameter int N_TCU = 8,
  parameter int ID_W  = 32,
  parameter int RW    = 4
) (
  input  logic                   active,
  input  logic [ID_W:0]          nxt,
  input  logic [ID_W:0]          hi_ext,
  input  logic [N_TCU-1:0]       elig,
  input  logic [N_TCU*RW-1:0]    rank_flat,
  input  logic [RW-1:0]          total,
  output logic [N_TCU-1:0]       grant_d,
  output logic [N_TCU-1:0]       nowork_d,
  output logic [N_TCU*ID_W-1:0]  id_d,
  output logic [ID_W:0]          adv
);
  localparam int XW = ID_W + 1;

  logic [XW-1:0] avail;
  logic [XW-1:0] total_ext;

  always_comb begin
    if (nxt <= hi_ext) avail = hi_ext - nxt + XW'(1);
    else               avail = '0;
    total_ext = XW'(total);
    if (!active)                adv = '0;
    else if (total_ext < avail) adv = total_ext;
    else                        adv = avail;
  end

  for (genvar g = 0; g < N_TCU; g++) begin : g_slot
    logic [RW-1:0] rk;
    logic          hit;
    assign rk  = rank_flat[g*RW +: RW];
    assign hit = active & elig[g] & (XW'(rk) < avail);
    assign grant_d[g]             = hit;
    assign nowork_d[g]            = elig[g] & ~hit;
    assign id_d[g*ID_W +: ID_W]   = nxt[ID_W-1:0] + ID_W'(rk);
  end
endmodule

// File: rtl/sjs_occupancy.sv
// Tracks which TCUs currently hold a thread.
module sjs_occupancy #(
  parameter int N_TCU = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TCU-1:0] grant_d,
  input  logic [N_TCU-1:0] done,
  output logic [N_TCU-1:0] busy_q,
  output logic             any_busy
);
  logic [N_TCU-1:0] busy_d;
  logic             busy_en;

  always_comb begin
    busy_d  = (busy_q & ~done) | grant_d;
    busy_en = |(grant_d | (busy_q & done));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= '0;
    else if (busy_en) busy_q <= busy_d;
  end

  assign any_busy = |busy_q;
endmodule

// File: rtl/spawn_join_sched.sv
module spawn_join_sched #(
  parameter int N_TCU = 8,
  parameter int ID_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spawn_valid,
  input  logic [ID_W-1:0]       spawn_lo,
  input  logic [ID_W-1:0]       spawn_hi,
  output logic                  spawn_ack,
  output logic                  spawn_err,
  output logic                  region_busy,
  output logic                  join_done,
  input  logic [N_TCU-1:0]      tcu_req,
  input  logic [N_TCU-1:0]      tcu_done,
  output logic [N_TCU-1:0]      tcu_grant,
  output logic [N_TCU-1:0]      tcu_nowork,
  output logic [N_TCU*ID_W-1:0] tcu_id
);
  import sjs_pkg::*;

  localparam int RW = $clog2(N_TCU + 1);
  localparam int XW = ID_W + 1;

  logic rst_i_n;

  sjs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Region state
  rgn_state_e rgn_q, rgn_d;
  logic [XW-1:0] nxt_q, nxt_d;
  logic [XW-1:0] hi_q;
  logic          nxt_en;

  logic          active, exhausted, join_fire, accept, reject;
  logic [N_TCU-1:0] busy_q, elig;
  logic             any_busy;

  logic [N_TCU*RW-1:0]   rank_flat;
  logic [RW-1:0]         total;
  logic [N_TCU-1:0]      grant_d, nowork_d;
  logic [N_TCU*ID_W-1:0] id_d;
  logic [XW-1:0]         adv;

  assign active = (rgn_q == RGN_RUN);
  assign elig   = tcu_req & ~busy_q;

  sjs_rank #(.N_TCU(N_TCU), .RW(RW)) u_rank (
    .elig      (elig),
    .rank_flat (rank_flat),
    .total     (total)
  );

  sjs_issue #(.N_TCU(N_TCU), .ID_W(ID_W), .RW(RW)) u_issue (
    .active    (active),
    .nxt       (nxt_q),
    .hi_ext    (hi_q),
    .elig      (elig),
    .rank_flat (rank_flat),
    .total     (total),
    .grant_d   (grant_d),
    .nowork_d  (nowork_d),
    .id_d      (id_d),
    .adv       (adv)
  );

  sjs_occupancy #(.N_TCU(N_TCU)) u_occ (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .grant_d  (grant_d),
    .done     (tcu_done),
    .busy_q   (busy_q),
    .any_busy (any_busy)
  );

  // Next-state logic
  always_comb begin
    exhausted = nxt_q > hi_q;
    join_fire = active & exhausted & ~any_busy;
    accept    = spawn_valid & ~active;
    reject    = spawn_valid & active;

    rgn_d = rgn_q;
    if (join_fire)   rgn_d = RGN_IDLE;
    else if (accept) rgn_d = RGN_RUN;

    nxt_d  = nxt_q + adv;
    nxt_en = active & (|grant_d);
    if (accept) begin
      nxt_d  = {1'b0, spawn_lo};
      nxt_en = 1'b1;
    end
  end

  // Region registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rgn_q <= RGN_IDLE;
      nxt_q <= '0;
      hi_q  <= '0;
    end else begin
      rgn_q <= rgn_d;
      if (nxt_en) nxt_q <= nxt_d;
      if (accept) hi_q  <= {1'b0, spawn_hi};
    end
  end

  // Response registers
  logic             ack_q, err_q, join_q;
  logic [N_TCU-1:0] grant_q, nowork_q;
  logic [ID_W-1:0]  id_q [N_TCU];

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ack_q    <= 1'b0;
      err_q    <= 1'b0;
      join_q   <= 1'b0;
      grant_q  <= '0;
      nowork_q <= '0;
    end else begin
      ack_q    <= accept;
      err_q    <= reject;
      join_q   <= join_fire;
      grant_q  <= grant_d;
      nowork_q <= nowork_d;
    end
  end

  for (genvar g = 0; g < N_TCU; g++) begin : g_idreg
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n)        id_q[g] <= '0;
      else if (grant_d[g]) id_q[g] <= id_d[g*ID_W +: ID_W];
    end
    assign tcu_id[g*ID_W +: ID_W] = id_q[g];
  end

  assign spawn_ack   = ack_q;
  assign spawn_err   = err_q;
  assign join_done   = join_q;
  assign region_busy = active;
  assign tcu_grant   = grant_q;
  assign tcu_nowork  = nowork_q;
endmodule

// File: rtl/sjs_checker.sv
module sjs_checker #(
  parameter int N_TCU = 8,
  parameter int ID_W  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  spawn_valid,
  input logic [ID_W-1:0]       spawn_lo,
  input logic [ID_W-1:0]       spawn_hi,
  input logic                  spawn_ack,
  input logic                  spawn_err,
  input logic                  region_busy,
  input logic                  join_done,
  input logic [N_TCU-1:0]      tcu_req,
  input logic [N_TCU-1:0]      tcu_grant,
  input logic [N_TCU-1:0]      tcu_nowork,
  input logic [N_TCU*ID_W-1:0] tcu_id
);
  logic [ID_W-1:0] cap_lo, cap_hi;
  logic            distinct_ok, range_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_lo <= '0;
      cap_hi <= '0;
    end else if (spawn_valid && !region_busy) begin
      cap_lo <= spawn_lo;
      cap_hi <= spawn_hi;
    end
  end

  always_comb begin
    distinct_ok = 1'b1;
    range_ok    = 1'b1;
    for (int i = 0; i < N_TCU; i++) begin
      if (tcu_grant[i]) begin
        if (tcu_id[i*ID_W +: ID_W] < cap_lo || tcu_id[i*ID_W +: ID_W] > cap_hi)
          range_ok = 1'b0;
        for (int j = i + 1; j < N_TCU; j++)
          if (tcu_grant[j] && tcu_id[i*ID_W +: ID_W] == tcu_id[j*ID_W +: ID_W])
            distinct_ok = 1'b0;
      end
    end
  end

  p_ack_err_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(spawn_ack && spawn_err));
  p_err_when_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_err |-> $past(region_busy));
  p_ack_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_ack |-> (region_busy && !$past(region_busy)));
  p_resp_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tcu_grant & tcu_nowork) == '0);
  p_resp_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((tcu_grant | tcu_nowork) & ~$past(tcu_req)) == '0);
  p_distinct_ids_r4: assert property (@(posedge clk) disable iff (!rst_n)
    distinct_ok);
  p_id_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    range_ok);
  p_join_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    join_done |-> (!region_busy && $past(region_busy)));
  p_no_grant_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tcu_grant != '0) |-> $past(region_busy));
endmodule

bind spawn_join_sched sjs_checker #(.N_TCU(N_TCU), .ID_W(ID_W)) u_sjs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spawn_valid (spawn_valid),
  .spawn_lo    (spawn_lo),
  .spawn_hi    (spawn_hi),
  .spawn_ack   (spawn_ack),
  .spawn_err   (spawn_err),
  .region_busy (region_busy),
  .join_done   (join_done),
  .tcu_req     (tcu_req),
  .tcu_grant   (tcu_grant),
  .tcu_nowork  (tcu_nowork),
  .tcu_id      (tcu_id)
);

// File: tb/test_spawn_join_sched.sv
module test_spawn_join_sched;
  localparam int NT = 4;
  localparam int IW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic             spawn_valid;
  logic [IW-1:0]    spawn_lo, spawn_hi;
  logic             spawn_ack, spawn_err, region_busy, join_done;
  logic [NT-1:0]    tcu_req, tcu_done, tcu_grant, tcu_nowork;
  logic [NT*IW-1:0] tcu_id;

  spawn_join_sched #(.N_TCU(NT), .ID_W(IW)) i_spawn_join_sched (
    .clk(clk), .rst_n(rst_n),
    .spawn_valid(spawn_valid), .spawn_lo(spawn_lo), .spawn_hi(spawn_hi),
    .spawn_ack(spawn_ack), .spawn_err(spawn_err),
    .region_busy(region_busy), .join_done(join_done),
    .tcu_req(tcu_req), .tcu_done(tcu_done),
    .tcu_grant(tcu_grant), .tcu_nowork(tcu_nowork), .tcu_id(tcu_id)
  );

  int total_n = 0;
  int bad_n   = 0;

  // Bench view of the region, kept from the requirements
  bit            m_active = 0;
  logic [IW:0]   m_next = '0, m_hi = '0;
  logic [IW-1:0] m_lo = '0;
  logic [NT-1:0] m_busy = '0;
  int            tcnt [NT];
  bit            seen [64];
  int            seen_cnt = 0;
  longint        region_sz = 0;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // One cycle: drive inputs, predict, sample after the edge, compare, update.
  task automatic cycle(input logic sv, input logic [IW-1:0] lo, input logic [IW-1:0] hi,
                       input logic [NT-1:0] req, input logic [NT-1:0] dn);
    logic [NT-1:0] e_grant, e_nowork, elig;
    logic [IW-1:0] e_id [NT];
    logic [IW:0]   avail;
    int            rank, gcnt;
    bit            e_ack, e_err, e_join;
    spawn_valid = sv; spawn_lo = lo; spawn_hi = hi;
    tcu_req = req; tcu_done = dn;
    e_grant = '0; e_nowork = '0; rank = 0; gcnt = 0;
    elig = req & ~m_busy;
    avail = (m_next <= m_hi) ? (m_hi - m_next + 1) : '0;
    for (int i = 0; i < NT; i++) begin
      e_id[i] = '0;
      if (elig[i]) begin
        if (m_active && (IW+1)'(rank) < avail) begin
          e_grant[i] = 1'b1;
          e_id[i] = m_next[IW-1:0] + IW'(rank);
          gcnt++;
        end else e_nowork[i] = 1'b1;
        rank++;
      end
    end
    e_join = m_active && (m_next > m_hi) && (m_busy == '0);
    e_ack  = sv && !m_active;
    e_err  = sv && m_active;

    @(negedge clk);
    chk(spawn_ack == e_ack, "R1 spawn_ack", 64'(spawn_ack), 64'(e_ack));
    chk(spawn_err == e_err, "R2 spawn_err", 64'(spawn_err), 64'(e_err));
    chk(join_done == e_join, "R8 join_done", 64'(join_done), 64'(e_join));
    chk(tcu_grant == e_grant, "R3 tcu_grant", 64'(tcu_grant), 64'(e_grant));
    if (!m_active)
      chk(tcu_nowork == e_nowork, "R10 tcu_nowork", 64'(tcu_nowork), 64'(e_nowork));
    else
      chk(tcu_nowork == e_nowork, "R6 tcu_nowork", 64'(tcu_nowork), 64'(e_nowork));
    for (int i = 0; i < NT; i++) begin
      if (req[i] && m_busy[i])
        chk(!tcu_grant[i] && !tcu_nowork[i], "R7 busy request answered",
            64'({tcu_grant[i], tcu_nowork[i]}), 64'(0));
      if (e_grant[i] && tcu_grant[i]) begin
        logic [IW-1:0] off;
        chk(tcu_id[i*IW +: IW] == e_id[i], "R4 granted id", 64'(tcu_id[i*IW +: IW]), 64'(e_id[i]));
        off = tcu_id[i*IW +: IW] - m_lo;
        if (off < 64) begin
          chk(!seen[off], "R5 duplicate id", 64'(tcu_id[i*IW +: IW]), 64'(0));
          seen[off] = 1;
          seen_cnt++;
        end else chk(0, "R5 id out of range", 64'(tcu_id[i*IW +: IW]), 64'(m_lo));
      end
    end

    // update bench view
    for (int i = 0; i < NT; i++) begin
      if (m_busy[i] && !dn[i] && tcnt[i] > 0) tcnt[i]--;
      if (e_grant[i]) tcnt[i] = int'(lfsr[3:0]) % 4;
    end
    m_busy = (m_busy & ~dn) | e_grant;
    m_next = m_next + (IW+1)'(gcnt);
    if (e_join) m_active = 0;
    if (e_ack) begin
      m_active = 1;
      m_next = {1'b0, lo};
      m_hi = {1'b0, hi};
      m_lo = lo;
      for (int k = 0; k < 64; k++) seen[k] = 0;
      seen_cnt = 0;
      region_sz = (hi >= lo) ? longint'(hi) - longint'(lo) + 1 : 0;
    end
    chk(region_busy == m_active, "R1 region_busy", 64'(region_busy), 64'(m_active));
  endtask

  task automatic run_region(input logic [IW-1:0] lo, input logic [IW-1:0] hi, input int pat);
    int lim = 0;
    cycle(1'b1, lo, hi, '0, '0);
    while (m_active && lim < 300) begin
      logic [NT-1:0] req, dn;
      logic sv;
      step_lfsr();
      req = '0; dn = '0;
      for (int i = 0; i < NT; i++) begin
        if (!m_busy[i]) begin
          if (pat == 0 || lfsr[(i + pat) % 16]) req[i] = 1'b1;
          if (pat % 3 == 2 && lfsr[14] && i == 1) dn[i] = 1'b1;   // R7 stray done
        end else begin
          if (tcnt[i] == 0) dn[i] = 1'b1;
          else if (pat % 3 == 1 && lfsr[15]) req[i] = 1'b1;        // R7 busy request
        end
      end
      sv = (lim == 2) && (pat % 2 == 1);                            // R2 nested spawn
      cycle(sv, lo + 7, hi + 9, req, dn);
      lim++;
    end
    chk(!m_active, "R8 region never closed", 64'(m_active), 64'(0));
    chk(longint'(seen_cnt) == region_sz, "R5 ids issued per region", 64'(seen_cnt), 64'(region_sz));
    if (region_sz == 0)
      chk(seen_cnt == 0, "R9 empty region issued ids", 64'(seen_cnt), 64'(0));
    if (hi == '1)
      chk(longint'(seen_cnt) == region_sz, "R11 top range count", 64'(seen_cnt), 64'(region_sz));
    cycle(1'b0, '0, '0, '0, '0);
  endtask

  bit finished = 0;

  initial begin
    for (int i = 0; i < NT; i++) tcnt[i] = 0;
    for (int k = 0; k < 64; k++) seen[k] = 0;
    rst_n = 1'b0; spawn_valid = 1'b0; spawn_lo = '0; spawn_hi = '0;
    tcu_req = '0; tcu_done = '0;
    repeat (3) @(negedge clk);
    chk({spawn_ack, spawn_err, region_busy, join_done, tcu_grant, tcu_nowork} == '0,
        "R1 reset outputs", 64'({spawn_ack, spawn_err, region_busy, join_done, tcu_grant, tcu_nowork}), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(region_busy == 1'b0, "R1 idle after reset", 64'(region_busy), 64'(0));

    // R10: requests with nothing open
    cycle(1'b0, '0, '0, 4'hF, '0);
    cycle(1'b0, '0, '0, 4'h5, '0);

    // R9: high below low, checked against exact pulse timing
    cycle(1'b1, 32'd500, 32'd3, '0, '0);
    cycle(1'b0, '0, '0, 4'hF, '0);
    cycle(1'b0, '0, '0, '0, '0);

    // Sweep region sizes against contention / duration patterns
    for (int sz = 0; sz <= 10; sz++)
      for (int pat = 0; pat < 6; pat++)
        run_region(32'h1000 + 32'(sz * 64 + pat), 32'h1000 + 32'(sz * 64 + pat) + 32'(sz) - 32'd1, pat);

    // R11: range at the top of the ID space
    run_region(32'hFFFF_FFFC, 32'hFFFF_FFFF, 0);
    run_region(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3);
    // R6: more requesters than IDs
    run_region(32'd20, 32'd21, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total_n++;
      bad_n++;
      $display("FAIL watchdog R8 run did not end actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end
endmodule